// File: doc/BRIEF.md
# Interleaved Block Transfer Sequencer

This block is the master engine for block moves between a local memory port and a backplane bus port. Once it has a start command, it runs the whole move by itself. It requests the backplane, performs one beat at a time as a local access paired with a backplane access, and keeps one address counter per side. A single backplane tenure is never allowed to run across a 256-byte address boundary, and it may also be capped at a programmed number of beats.

When a tenure ends before the move is done, the block drops its bus request. It then waits out a programmed interleave period, during which it flags that slave accesses from the backplane may be served. After that it arbitrates again. Both address counters are held across the pause, so the move resumes exactly where it stopped. Completion raises a local interrupt. A bus error on either side aborts the move.

The direction input picks one of two orders. Local-to-backplane reads local memory and writes the backplane. Backplane-to-local reads the backplane and writes local memory. In both cases the block is master of the local port.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy, bus_req, bp_stb, lc_stb, done_irq and err_flag are all 0.
- R2: A start pulse taken while idle with nonzero length makes busy and bus_req 1 from the next cycle on. A start pulse taken while busy is ignored: addresses, beat count and chunking continue unchanged.
- R3: With dir_in=0, each beat is a local read (lc_we=0) followed by a backplane write (bp_we=1) whose wdata is the local data just read. With dir_in=1, each beat is a backplane read (bp_we=0) followed by a local write (lc_we=1) carrying the backplane data.
- R4: size_in selects the beat size: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Each side's address starts at its base and advances by the beat size after each acknowledged access on that side. The move takes ceil(len/size) beats.
- R5: A backplane tenure ends (bus_req drops) after any beat whose backplane access carries out of address bits 7:0, provided bytes remain.
- R6: A backplane tenure also ends after burst_in beats when burst_in is nonzero. A value of 0 means no beat limit.
- R7: Between tenures, bus_req stays 0 for exactly ilv_in+1 cycles. During that time slave_win is 1 and both addresses are held.
- R8: On completion, busy falls and done_irq rises and stays 1 until the next accepted start. A start with length 0 sets done_irq in the next cycle without requesting the bus.
- R9: An error (bp_err while bp_stb, or lc_err while lc_stb) aborts the move. In the next cycle busy=0, bus_req=0 and err_flag=1, and done_irq stays 0.
- R10: bp_stb and lc_stb are never 1 together, and bp_stb is 1 only while bus_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command pulse |
| dir_in | input | 1 | 0: local to backplane, 1: backplane to local |
| len_in | input | LW | Total bytes to move |
| size_in | input | 2 | Beat size code |
| burst_in | input | BW | Beat limit per tenure, 0 = none |
| ilv_in | input | IW | Interleave period in cycles (plus one) |
| bp_base | input | AW | Backplane start address |
| lc_base | input | AW | Local start address |
| bus_gnt | input | 1 | Backplane grant |
| bp_ack | input | 1 | Backplane access acknowledge |
| bp_err | input | 1 | Backplane bus error |
| bp_rdata | input | DW | Backplane read data |
| lc_ack | input | 1 | Local access acknowledge |
| lc_err | input | 1 | Local bus error |
| lc_rdata | input | DW | Local read data |
| bus_req | output | 1 | Backplane request, held through a tenure |
| bp_stb | output | 1 | Backplane access strobe |
| bp_we | output | 1 | Backplane access is a write |
| bp_addr | output | AW | Backplane address counter |
| lc_stb | output | 1 | Local access strobe |
| lc_we | output | 1 | Local access is a write |
| lc_addr | output | AW | Local address counter |
| wdata | output | DW | Write data for whichever side is written |
| slave_win | output | 1 | Interleave period active, slave accesses allowed |
| busy | output | 1 | Move in progress |
| done_irq | output | 1 | Completion interrupt |
| err_flag | output | 1 | Move aborted by bus error |

## Verification
Directed moves are placed so that a tenure ends at the 256-byte carry with both 1-byte and 4-byte beats. Another directed move ends tenures on the beat limit only. Together these separate boundary splitting from burst capping. Random moves mix both directions, all beat sizes, unaligned bases, beat limits and interleave lengths, with randomly delayed grants and acknowledges. Every handshake's address and data is compared against a bench model, and every pause length is measured. Separate cases cover zero length, a start pulse arriving mid-move, and an injected local error, to show the ignore, immediate-done and abort paths.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int BW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_in,
  input  logic [LW-1:0] len_in,
  input  logic [1:0]    size_in,
  input  logic [BW-1:0] burst_in,
  input  logic [IW-1:0] ilv_in,
  input  logic [AW-1:0] bp_base,
  input  logic [AW-1:0] lc_base,
  input  logic          bus_gnt,
  input  logic          bp_ack,
  input  logic          bp_err,
  input  logic [DW-1:0] bp_rdata,
  input  logic          lc_ack,
  input  logic          lc_err,
  input  logic [DW-1:0] lc_rdata,
  output logic          bus_req,
  output logic          bp_stb,
  output logic          bp_we,
  output logic [AW-1:0] bp_addr,
  output logic          lc_stb,
  output logic          lc_we,
  output logic [AW-1:0] lc_addr,
  output logic [DW-1:0] wdata,
  output logic          slave_win,
  output logic          busy,
  output logic          done_irq,
  output logic          err_flag
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_P1, S_P2, S_ILV} st_t;

  st_t           st;
  logic          dir_q, wrap_q, irq_q, err_q;
  logic [2:0]    sz_q, sz_dec;
  logic [LW-1:0] rem_q;
  logic [BW-1:0] burst_q, cnt_q, cnt_nx;
  logic [IW-1:0] ilv_q, ilv_cnt;
  logic [AW-1:0] bp_a, lc_a, bp_nx, lc_nx;
  logic [DW-1:0] data_q;
  logic [8:0]    bp_sum;
  logic          hs, fault, last, brk;

  assign sz_dec = (size_in == 2'd0) ? 3'd1 : (size_in == 2'd1) ? 3'd2 : 3'd4;

  assign lc_stb = (st == S_P1 && !dir_q) || (st == S_P2 && dir_q);
  assign bp_stb = (st == S_P1 && dir_q) || (st == S_P2 && !dir_q);
  assign lc_we  = dir_q;
  assign bp_we  = !dir_q;

  assign hs    = (lc_stb && lc_ack) || (bp_stb && bp_ack);
  assign fault = (lc_stb && lc_err) || (bp_stb && bp_err);

  assign bp_sum = {1'b0, bp_a[7:0]} + {6'b0, sz_q};
  assign bp_nx  = bp_a + {{(AW-3){1'b0}}, sz_q};
  assign lc_nx  = lc_a + {{(AW-3){1'b0}}, sz_q};
  assign cnt_nx = cnt_q + 1'b1;
  assign last   = rem_q <= {{(LW-3){1'b0}}, sz_q};
  assign brk    = (dir_q ? wrap_q : bp_sum[8]) || (burst_q != '0 && cnt_nx == burst_q);

  assign bus_req   = (st == S_REQ) || (st == S_P1) || (st == S_P2);
  assign slave_win = (st == S_ILV);
  assign busy      = (st != S_IDLE);
  assign bp_addr   = bp_a;
  assign lc_addr   = lc_a;
  assign wdata     = data_q;
  assign done_irq  = irq_q;
  assign err_flag  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dir_q   <= 1'b0;
      wrap_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      sz_q    <= 3'd1;
      rem_q   <= '0;
      burst_q <= '0;
      cnt_q   <= '0;
      ilv_q   <= '0;
      ilv_cnt <= '0;
      bp_a    <= '0;
      lc_a    <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dir_q   <= dir_in;
          sz_q    <= sz_dec;
          rem_q   <= len_in;
          burst_q <= burst_in;
          ilv_q   <= ilv_in;
          bp_a    <= bp_base;
          lc_a    <= lc_base;
          cnt_q   <= '0;
          err_q   <= 1'b0;
          irq_q   <= (len_in == '0);
          st      <= (len_in == '0) ? S_IDLE : S_REQ;
        end
        S_REQ: if (bus_gnt) st <= S_P1;
        S_P1: begin
          if (fault) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (hs) begin
            data_q <= dir_q ? bp_rdata : lc_rdata;
            if (dir_q) begin
              bp_a   <= bp_nx;
              wrap_q <= bp_sum[8];
            end else begin
              lc_a <= lc_nx;
            end
            st <= S_P2;
          end
        end
        S_P2: begin
          if (fault) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (hs) begin
            if (dir_q) lc_a <= lc_nx;
            else       bp_a <= bp_nx;
            rem_q <= last ? '0 : rem_q - {{(LW-3){1'b0}}, sz_q};
            if (last) begin
              irq_q <= 1'b1;
              st    <= S_IDLE;
            end else if (brk) begin
              cnt_q   <= '0;
              ilv_cnt <= ilv_q;
              st      <= S_ILV;
            end else begin
              cnt_q <= cnt_nx;
              st    <= S_P1;
            end
          end
        end
        S_ILV: begin
          if (ilv_cnt == '0) st <= S_REQ;
          else ilv_cnt <= ilv_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bp_stb,
  input logic          bp_ack,
  input logic          bp_err,
  input logic          lc_stb,
  input logic          lc_ack,
  input logic          lc_err,
  input logic [AW-1:0] bp_addr,
  input logic [AW-1:0] lc_addr,
  input logic          slave_win,
  input logic          busy,
  input logic          done_irq,
  input logic          err_flag
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !bp_stb && !lc_stb)); // R1

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_stb && lc_stb)); // R10

  AST_BP_STB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bp_stb |-> bus_req); // R10

  AST_WIN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    slave_win |-> (!bus_req && busy)); // R7

  AST_BP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bp_stb && bp_ack)) |-> $stable(bp_addr)); // R4

  AST_LC_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(lc_stb && lc_ack)) |-> $stable(lc_addr)); // R4

  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bp_stb && bp_err) || (lc_stb && lc_err)) |=> (!busy && !bus_req && err_flag)); // R9

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> !busy); // R8

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bp_stb(bp_stb), .bp_ack(bp_ack),
  .bp_err(bp_err), .lc_stb(lc_stb), .lc_ack(lc_ack), .lc_err(lc_err),
  .bp_addr(bp_addr), .lc_addr(lc_addr), .slave_win(slave_win), .busy(busy),
  .done_irq(done_irq), .err_flag(err_flag)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int AW = 32, DW = 32, LW = 16, BW = 8, IW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dir_in = 0;
  logic [LW-1:0] len_in = '0;
  logic [1:0] size_in = '0;
  logic [BW-1:0] burst_in = '0;
  logic [IW-1:0] ilv_in = '0;
  logic [AW-1:0] bp_base = '0, lc_base = '0;
  logic bus_gnt = 0, bp_ack = 0, bp_err = 0, lc_ack = 0, lc_err = 0;
  logic [DW-1:0] bp_rdata, lc_rdata;
  logic bus_req, bp_stb, bp_we, lc_stb, lc_we, slave_win, busy, done_irq, err_flag;
  logic [AW-1:0] bp_addr, lc_addr;
  logic [DW-1:0] wdata;

  always #2 clk = ~clk;

  blk_xfer_seq #(.AW(AW), .DW(DW), .LW(LW), .BW(BW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in), .len_in(len_in),
    .size_in(size_in), .burst_in(burst_in), .ilv_in(ilv_in), .bp_base(bp_base),
    .lc_base(lc_base), .bus_gnt(bus_gnt), .bp_ack(bp_ack), .bp_err(bp_err),
    .bp_rdata(bp_rdata), .lc_ack(lc_ack), .lc_err(lc_err), .lc_rdata(lc_rdata),
    .bus_req(bus_req), .bp_stb(bp_stb), .bp_we(bp_we), .bp_addr(bp_addr),
    .lc_stb(lc_stb), .lc_we(lc_we), .lc_addr(lc_addr), .wdata(wdata),
    .slave_win(slave_win), .busy(busy), .done_irq(done_irq), .err_flag(err_flag));

  function automatic logic [DW-1:0] pat_l(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction
  function automatic logic [DW-1:0] pat_b(input logic [AW-1:0] a);
    return ~(a * 32'h85EB_CA6B) ^ 32'h0F0F_3C3C;
  endfunction
  function automatic int sz_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  assign lc_rdata = pat_l(lc_addr);
  assign bp_rdata = pat_b(bp_addr);

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic e_dir, e_wrap, inj_err = 0;
  int e_sz, e_rem, e_cnt, e_burst, e_ilv, gaps_exp, gaps_seen, gap_len, beats_seen;
  logic [AW-1:0] e_bp, e_lc, prev_bp;
  logic [DW-1:0] e_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      finish_run();
    end
  end

  task automatic end_beat();
    beats_seen++;
    e_cnt++;
    e_rem = (e_rem <= e_sz) ? 0 : e_rem - e_sz;
    if (e_rem != 0 && (e_wrap || (e_burst != 0 && e_cnt == e_burst))) begin
      gaps_exp++;
      e_cnt = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bus_gnt = bus_req && ($urandom % 2 == 0);
      bp_ack  = bp_stb && ($urandom % 3 != 0);
      bp_err  = 1'b0;
      if (inj_err && lc_stb) begin
        lc_err = 1'b1; lc_ack = 1'b0; inj_err = 1'b0;
      end else begin
        lc_err = 1'b0;
        lc_ack = lc_stb && ($urandom % 3 != 0);
      end
      if (busy && !bus_req) begin
        gap_len++;
        chk("R7 slave_win in pause", slave_win, 1);
        chk("R7 bp addr held", bp_addr, e_bp);
        chk("R7 lc addr held", lc_addr, e_lc);
      end else if (gap_len > 0) begin
        chk("R7 pause length", gap_len, e_ilv + 1);
        gaps_seen++;
        gap_len = 0;
      end
      if (lc_stb && lc_ack) begin
        chk("R4 lc addr", lc_addr, e_lc);
        chk("R3 lc_we", lc_we, e_dir);
        if (e_dir) chk("R3 local write data", wdata, pat_b(prev_bp));
        else e_data = pat_l(e_lc);
        e_lc = e_lc + e_sz;
        if (e_dir) end_beat();
      end
      if (bp_stb && bp_ack) begin
        chk("R4 bp addr", bp_addr, e_bp);
        chk("R3 bp_we", bp_we, !e_dir);
        chk("R10 bus held", bus_req, 1);
        if (!e_dir) chk("R3 backplane write data", wdata, e_data);
        else prev_bp = e_bp;
        e_wrap = ({1'b0, e_bp[7:0]} + 9'(e_sz)) > 9'd255;
        e_bp = e_bp + e_sz;
        if (!e_dir) end_beat();
      end
    end
  end

  task automatic run(input logic d, input int len, input logic [1:0] sc, input int bu,
                     input int il, input logic [AW-1:0] bb, input logic [AW-1:0] lb,
                     input bit poke, input bit err);
    int beats_exp, guard;
    @(negedge clk); #1;
    e_dir = d; e_sz = sz_of(sc); e_rem = len; e_cnt = 0; e_burst = bu; e_ilv = il;
    e_bp = bb; e_lc = lb; gaps_exp = 0; gaps_seen = 0; gap_len = 0; beats_seen = 0;
    e_wrap = 0;
    beats_exp = (len + e_sz - 1) / e_sz;
    dir_in = d; len_in = LW'(len); size_in = sc; burst_in = BW'(bu); ilv_in = IW'(il);
    bp_base = bb; lc_base = lb; start = 1;
    @(negedge clk); #1;
    start = 0;
    chk("R2 busy after start", busy, 1);
    chk("R2 bus_req after start", bus_req, 1);
    chk("R2 irq cleared", done_irq, 0);
    if (err) inj_err = 1;
    if (poke) begin
      repeat (5) @(negedge clk);
      #1;
      dir_in = !d; len_in = 16'd3; bp_base = 32'hDEAD_0000; lc_base = 32'h0BAD_0000; start = 1;
      @(negedge clk); #1;
      start = 0;
      chk("R2 still busy after ignored start", busy, 1);
    end
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk); #1;
      guard++;
    end
    @(negedge clk); #1;
    chk("R8/R9 move ended", busy, 0);
    chk("R9 bus_req released", bus_req, 0);
    if (err) begin
      chk("R9 err_flag", err_flag, 1);
      chk("R9 no irq on abort", done_irq, 0);
      inj_err = 0;
    end else begin
      chk("R8 done_irq", done_irq, 1);
      chk("R8 no err", err_flag, 0);
      chk("R4 beat count", beats_seen, beats_exp);
      chk("R5/R6 tenure splits", gaps_seen, gaps_exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 strobes", {bp_stb, lc_stb}, 0);
    chk("R1 irq/err", {done_irq, err_flag}, 0);
    rst_n = 1;
    void'($urandom(32'd1957));
    repeat (2) @(negedge clk);

    run(0, 64, 2'd2, 0, 5, 32'h0000_00F0, 32'h0004_0000, 0, 0);  // R5 4-byte carry
    run(1, 6, 2'd0, 0, 0, 32'h0000_01FE, 32'h0000_2000, 0, 0);   // R5 1-byte carry, R3 read
    run(0, 40, 2'd1, 4, 3, 32'h0000_1000, 32'h0000_3000, 0, 0);  // R6 beat limit
    run(1, 600, 2'd3, 0, 7, 32'h0001_0000, 32'h0000_0100, 0, 0); // R5 several boundaries
    run(0, 7, 2'd2, 0, 2, 32'h0000_0010, 32'h0000_0010, 0, 0);   // R4 partial last beat
    run(0, 50, 2'd0, 0, 1, 32'h0000_5000, 32'h0000_6000, 1, 0);  // R2 ignored start
    run(1, 80, 2'd2, 0, 1, 32'h0000_7000, 32'h0000_8000, 0, 1);  // R9 abort

    @(negedge clk); #1;
    len_in = '0; start = 1;
    @(negedge clk); #1;
    start = 0;
    chk("R8 zero length no busy", busy, 0);
    chk("R8 zero length no request", bus_req, 0);
    chk("R8 zero length irq", done_irq, 1);
    chk("R9 err cleared by start", err_flag, 0);

    for (int i = 0; i < 20; i++) begin
      logic [1:0] sc = 2'($urandom % 4);
      int bu = ($urandom % 2 == 0) ? 0 : 1 + $urandom % 16;
      run(1'($urandom % 2), 1 + $urandom % 400, sc, bu, $urandom % 20,
          $urandom, $urandom, 0, 0);
    end
    finish_run();
  end
endmodule